// File: doc/BRIEF.md
# ADC Timebase Divider

This block derives the timing enables an ADC controller needs from a single parent clock. Software writes one 32-bit configuration word that holds three ratios. The first ratio divides the parent clock into a conversion-clock enable. The other two count conversion-clock enables, not parent cycles, and produce a 10 microsecond tick and a 1 millisecond tick. Software picks the ratios so that the conversion clock stays inside the converter's legal band, which is 20 kHz to 200 kHz for the slow converter variant. Each ratio field holds its division ratio minus one.

All three outputs are enable pulses in the parent clock domain, so downstream logic needs no second clock. Any write to the word clears all three counters in the same edge. The new ratios therefore start from a clean phase, and the first tick after a write comes a full period later. The current word can always be read back.

Top module: `adc_timebase`

## Requirements
- R1: `rd_data` shows the configuration word. From the cycle after a write with `wr_en` high, it equals the value written.
- R2: An active-low asynchronous reset clears the word and all counters to zero. Before any write, every tick output is therefore high in every cycle.
- R3: Bits [7:0] hold M. `conv_tick` is high in the cycles k where (k+1) is a multiple of M+1, with k counted from 0 at the first cycle after the last write edge.
- R4: Bits [15:8] hold T. `tick_10us` is high exactly in the cycles with the (T+1)-th, 2(T+1)-th, … conversion tick after the last write, and only together with `conv_tick`.
- R5: Bits [31:16] hold S. `tick_1ms` is high exactly in the cycles with the (S+1)-th, 2(S+1)-th, … conversion tick after the last write, and only together with `conv_tick`.
- R6: A field value of 0 means divide by one. That stage then ticks on every enable at its input.
- R7: A write clears all three counters at the write edge, whatever phase they were in. A write with M > 0 is followed by a cycle with `conv_tick` low.
- R8: When a stage's ratio is greater than one, its tick is high for exactly one parent cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Current configuration word |
| conv_tick | output | 1 | Conversion-clock enable pulse |
| tick_10us | output | 1 | 10 microsecond enable pulse |
| tick_1ms | output | 1 | 1 millisecond enable pulse |

## Verification
Random configuration words with small ratios are written at arbitrary phases. Each of the three outputs is compared in every cycle against a cycle-count model. This separates a slow stage that counts parent cycles from one that counts conversion ticks, and shows whether a write restarts the counters. Directed words cover the all-zero word (divide by one everywhere), the largest main ratio, and the largest millisecond ratio, which exercises the full width of each counter. A rewrite in the middle of a period checks the restart, and a readback after every write checks the field placement.

// File: rtl/atb_pkg.sv
package atb_pkg;
    localparam int MAIN_W = 8;
    localparam int US_W   = 8;
    localparam int MS_W   = 16;
    localparam int WORD_W = MAIN_W + US_W + MS_W;

    // field order sets the bit positions: ms on top, main ratio at the bottom
    typedef struct packed {
        logic [MS_W-1:0]   ms_m1;
        logic [US_W-1:0]   us_m1;
        logic [MAIN_W-1:0] main_m1;
    } cfg_t;
endpackage

// File: rtl/atb_cfg_reg.sv
module atb_cfg_reg
    import atb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d = cfg_t'(wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R1
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> cfg_q == cfg_t'($past(wr_data)));
endmodule

// File: rtl/atb_div_stage.sv
module atb_div_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en_in,
    input  logic [W-1:0] lim,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic hit;

    always_comb begin
        st_d = st_q;
        hit  = en_in && (st_q.cnt == lim);
        if (clr)        st_d.cnt = '0;
        else if (en_in) st_d.cnt = hit ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = hit;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= lim);

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0 && !clr) |=> !tick);
endmodule

// File: rtl/adc_timebase.sv
module adc_timebase
    import atb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              conv_tick,
    output logic              tick_10us,
    output logic              tick_1ms
);
    cfg_t cfg;

    atb_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cfg(cfg)
    );

    atb_div_stage #(.W(MAIN_W)) u_main (
        .clk(clk), .rst_n(rst_n), .clr(wr_en), .en_in(1'b1),
        .lim(cfg.main_m1), .tick(conv_tick)
    );

    atb_div_stage #(.W(US_W)) u_us (
        .clk(clk), .rst_n(rst_n), .clr(wr_en), .en_in(conv_tick),
        .lim(cfg.us_m1), .tick(tick_10us)
    );

    atb_div_stage #(.W(MS_W)) u_ms (
        .clk(clk), .rst_n(rst_n), .clr(wr_en), .en_in(conv_tick),
        .lim(cfg.ms_m1), .tick(tick_1ms)
    );

    assign rd_data = cfg;

    // R4
    us_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_10us |-> conv_tick);

    // R5
    ms_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1ms |-> conv_tick);

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MAIN_W-1:0] != '0) |=> !conv_tick);
endmodule

// File: tb/adc_timebase_tb.sv
module adc_timebase_tb;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        conv_tick, tick_10us, tick_1ms;

    int checks = 0;
    int errors = 0;
    int unsigned n_main = 1, n_us = 1, n_ms = 1;
    int unsigned k = 0;

    always #(PERIOD/2) clk = ~clk;

    adc_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .conv_tick(conv_tick), .tick_10us(tick_10us),
        .tick_1ms(tick_1ms)
    );

    function automatic bit exp_tick(int unsigned cyc, int unsigned period);
        return ((cyc + 1) % period) == 0;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (k=%0d)", tag, act, exp, k);
        end
    endtask

    task automatic check_cycle();
        bit ec, eu, em, pc;
        ec = exp_tick(k, n_main);
        eu = exp_tick(k, n_main * n_us);
        em = exp_tick(k, n_main * n_ms);
        pc = (k > 0) && exp_tick(k - 1, n_main) && n_main > 1;
        check(conv_tick == ec, pc ? "R8 conv width" : "R3 conv", 32'(conv_tick), 32'(ec));
        check(tick_10us == eu, "R4 tick_10us", 32'(tick_10us), 32'(eu));
        check(tick_1ms == em, "R5 tick_1ms", 32'(tick_1ms), 32'(em));
    endtask

    task automatic write_word(logic [31:0] w);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = $urandom;
        n_main  = 32'(w[7:0]) + 1;
        n_us    = 32'(w[15:8]) + 1;
        n_ms    = 32'(w[31:16]) + 1;
        k       = 0;
        check(rd_data == w, "R1 readback", rd_data, w);
    endtask

    task automatic run(int unsigned cycles);
        for (int unsigned i = 0; i < cycles; i++) begin
            check_cycle();
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        #(PERIOD * 300000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state, cleared word, divide by one everywhere
        check(rd_data == 32'h0, "R2 reset word", rd_data, 32'h0);
        for (int i = 0; i < 4; i++) begin
            check(conv_tick && tick_10us && tick_1ms, "R2 reset ticks",
                  {29'b0, conv_tick, tick_10us, tick_1ms}, 32'h7);
            @(negedge clk);
        end
        // R6: zero fields after a nonzero word
        write_word(32'h0003_0202);
        run(40);
        write_word(32'h0000_0000);
        for (int i = 0; i < 5; i++) begin
            check(conv_tick && tick_10us && tick_1ms, "R6 divide by one",
                  {29'b0, conv_tick, tick_10us, tick_1ms}, 32'h7);
            @(negedge clk);
        end
        // R6: zero main field, nonzero slow fields
        write_word(32'h0004_0300);
        run(30);
        // R7: rewrite mid-period restarts the phase
        write_word(32'h0002_0105);
        run(9);
        write_word(32'h0002_0105);
        check(conv_tick == 1'b0, "R7 restart", 32'(conv_tick), 32'h0);
        run(60);
        // largest main ratio
        write_word(32'h0002_01ff);
        run(256 * 3 * 2 + 4);
        // largest millisecond ratio
        write_word(32'hffff_0000);
        run(65536 + 4);
        // random words at random phases
        for (int t = 0; t < 40; t++) begin
            logic [31:0] w;
            w = {16'($urandom_range(0, 9)), 8'($urandom_range(0, 5)),
                 8'($urandom_range(0, 7))};
            write_word(w);
            run($urandom_range(5, 150));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule